// File: doc/BRIEF.md
# Hold-and-Modify Colour Decoder

This block turns a packed hold-and-modify pixel stream into 24-bit RGB pixels. Bytes arrive over a valid/ready input and are gathered in groups of three; each group carries four 6-bit commands. Every command produces one output pixel. A command either copies one of eight base colours into a held colour register, averages the held colour with a base colour, or nudges a single channel of the held colour up or down by a small step. The pixel emitted for a command is the held colour after that command has been applied.

The eight base colours are driven in from outside as one flat bus. Base colour `i` occupies bits `[24*i+23 : 24*i]`, and red sits in the top byte, then green, then blue. A flag that travels with an input byte marks the start of a row. The byte carrying that flag resets the held colour to base colour 0 and becomes the first byte of a new group. Pixels leave through a registered valid/ready output.

Top module: `hamDecoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `pixValid` is 0 and `inReady` is 1.
- R2: Every three accepted input bytes form one 24-bit group, with the first byte in the top bits. The group yields exactly four pixels, decoded from bits [23:18], [17:12], [11:6] and [5:0], in that order.
- R3: A command whose top three bits are 000 sets the held colour to the base colour indexed by its low three bits, and outputs that colour.
- R4: A command whose top three bits are 001 sets each channel of the held colour to floor((held + base) / 2), where base is the base colour indexed by the low three bits.
- R5: For any other command, bits [5:4] select the channel (01 red, 10 green, 11 blue). Bit 3 selects the direction (0 add, 1 subtract). The step is the low three bits times 4. The other two channels are unchanged.
- R6: Channel adjustments saturate: an add never exceeds 255 and a subtract never goes below 0.
- R7: The held colour carries from one command to the next and across group boundaries.
- R8: A byte accepted with `inRowStart` set sets the held colour to base colour 0, discards any partly gathered group, and counts as the first byte of a new group.
- R9: While `pixValid` is 1 and `pixReady` is 0, `pixValid` stays 1 and `pixOut` does not change.
- R10: Once the third byte of a group is accepted, `inReady` stays 0 until the group's fourth pixel has been placed on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Packed command byte |
| inValid | input | 1 | Input byte is valid |
| inRowStart | input | 1 | Input byte begins a new row |
| inReady | output | 1 | Decoder can take a byte |
| baseColors | input | 192 | Eight base colours, entry i at bits [24*i+23:24*i] |
| pixOut | output | 24 | RGB pixel, red in bits [23:16] |
| pixValid | output | 1 | Output pixel is valid |
| pixReady | input | 1 | Sink takes the pixel |

## Verification
The hardest case to reach from the ports is a row restart that arrives while a group is only partly gathered. The half-built group must vanish without producing any pixel, and the restart must still reset the held colour. The stimulus sends two bytes without a row flag, then a full flagged group that opens with a channel adjustment. It then checks that exactly four pixels appear and that the first one is derived from base colour 0. A second hard case is a stalled output during emission. The sink is held not-ready after the third byte, and the bench checks that the pixel stays frozen and that input stays blocked before the sink is released.

// File: rtl/hamPkg.sv
package hamPkg;
  localparam int CHAN_W          = 8;
  localparam int NUM_CHAN        = 3;
  localparam int PIX_W           = CHAN_W * NUM_CHAN;
  localparam int CMD_W           = 6;
  localparam int FIELD_W         = CMD_W / 2;
  localparam int NUM_BASE        = 1 << FIELD_W;
  localparam int CMDS_PER_GROUP  = 4;
  localparam int BYTE_W          = 8;
  localparam int GROUP_W         = CMD_W * CMDS_PER_GROUP;
  localparam int BYTES_PER_GROUP = GROUP_W / BYTE_W;
  localparam int BCNT_W          = $clog2(BYTES_PER_GROUP + 1);
  localparam int SLOT_W          = $clog2(CMDS_PER_GROUP);
  localparam int DELTA_SHIFT     = 2;

  typedef enum logic [2:0] {
    OP_KEEP,
    OP_LOAD,
    OP_BLEND,
    OP_ADD,
    OP_SUB
  } chanOp_e;

  typedef struct packed {
    logic             issue;
    logic             rowReset;
    logic [CMD_W-1:0] cmd;
  } ctrlStrobe_t;
endpackage

// File: rtl/hamChanAlu.sv
module hamChanAlu
  import hamPkg::*;
(
  input  chanOp_e             op,
  input  logic [CHAN_W-1:0]   heldCh,
  input  logic [CHAN_W-1:0]   baseCh,
  input  logic [FIELD_W-1:0]  mag,
  output logic [CHAN_W-1:0]   result
);
  localparam int SUM_W = CHAN_W + 1;

  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] sum;

  assign step = SUM_W'(mag) << DELTA_SHIFT;

  always_comb begin
    sum    = '0;
    result = heldCh;
    case (op)
      OP_LOAD:  result = baseCh;
      OP_BLEND: begin
        sum    = {1'b0, heldCh} + {1'b0, baseCh};
        result = sum[SUM_W-1:1];
      end
      OP_ADD: begin
        sum    = {1'b0, heldCh} + step;
        result = sum[CHAN_W] ? '1 : sum[CHAN_W-1:0];
      end
      OP_SUB: begin
        sum    = {1'b0, heldCh} - step;
        result = sum[CHAN_W] ? '0 : sum[CHAN_W-1:0];
      end
      default:  result = heldCh;
    endcase
  end
endmodule

// File: rtl/hamCtrl.sv
module hamCtrl
  import hamPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inRowStart,
  output logic              inReady,
  input  logic              outFree,
  output ctrlStrobe_t       strobe
);
  logic [GROUP_W-1:0] groupReg;
  logic [GROUP_W-1:0] shifted;
  logic [BCNT_W-1:0]  byteCnt;
  logic [BCNT_W-1:0]  nextCnt;
  logic [SLOT_W-1:0]  slot;
  logic               groupFull;
  logic               accept;
  logic               issue;

  assign inReady = !groupFull;
  assign accept  = inValid && inReady;
  assign issue   = groupFull && outFree;
  assign nextCnt = inRowStart ? BCNT_W'(1) : byteCnt + 1'b1;
  assign shifted = groupReg << (slot * CMD_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupReg  <= '0;
      byteCnt   <= '0;
      slot      <= '0;
      groupFull <= 1'b0;
    end else if (accept) begin
      if (inRowStart) groupReg <= GROUP_W'(inData);
      else            groupReg <= {groupReg[GROUP_W-BYTE_W-1:0], inData};
      if (nextCnt == BCNT_W'(BYTES_PER_GROUP)) begin
        byteCnt   <= '0;
        slot      <= '0;
        groupFull <= 1'b1;
      end else begin
        byteCnt   <= nextCnt;
      end
    end else if (issue) begin
      slot <= slot + 1'b1;
      if (slot == SLOT_W'(CMDS_PER_GROUP - 1)) groupFull <= 1'b0;
    end
  end

  always_comb begin
    strobe.issue    = issue;
    strobe.rowReset = accept && inRowStart;
    strobe.cmd      = shifted[GROUP_W-1 -: CMD_W];
  end
endmodule

// File: rtl/hamDatapath.sv
module hamDatapath
  import hamPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [NUM_BASE*PIX_W-1:0] baseColors,
  input  logic                      pixReady,
  output logic [PIX_W-1:0]          pixOut,
  output logic                      pixValid,
  output logic                      outFree
);
  logic [FIELD_W-1:0] opField;
  logic [FIELD_W-1:0] dataField;
  logic [FIELD_W-2:0] chanSel;
  logic               negStep;
  logic               isLoad;
  logic               isBlend;
  logic [PIX_W-1:0]   held;
  logic [PIX_W-1:0]   baseSel;
  logic [PIX_W-1:0]   nextColor;

  assign {opField, dataField} = strobe.cmd;
  assign chanSel = opField[FIELD_W-1:1];
  assign negStep = opField[0];
  assign isLoad  = (opField == '0);
  assign isBlend = (opField == FIELD_W'(1));
  assign baseSel = baseColors[dataField*PIX_W +: PIX_W];
  assign outFree = !pixValid || pixReady;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    localparam int                 CODE_I = NUM_CHAN - c;
    localparam logic [FIELD_W-2:0] CODE   = CODE_I[FIELD_W-2:0];
    chanOp_e op;

    always_comb begin
      if (isLoad)               op = OP_LOAD;
      else if (isBlend)         op = OP_BLEND;
      else if (chanSel == CODE) op = negStep ? OP_SUB : OP_ADD;
      else                      op = OP_KEEP;
    end

    hamChanAlu u_alu (
      .op     (op),
      .heldCh (held[c*CHAN_W +: CHAN_W]),
      .baseCh (baseSel[c*CHAN_W +: CHAN_W]),
      .mag    (dataField),
      .result (nextColor[c*CHAN_W +: CHAN_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held     <= '0;
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      if (strobe.rowReset)   held <= baseColors[PIX_W-1:0];
      else if (strobe.issue) held <= nextColor;

      if (strobe.issue) begin
        pixOut   <= nextColor;
        pixValid <= 1'b1;
      end else if (pixReady) begin
        pixValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hamDecoder.sv
module hamDecoder
  import hamPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [BYTE_W-1:0]         inData,
  input  logic                      inValid,
  input  logic                      inRowStart,
  output logic                      inReady,
  input  logic [NUM_BASE*PIX_W-1:0] baseColors,
  output logic [PIX_W-1:0]          pixOut,
  output logic                      pixValid,
  input  logic                      pixReady
);
  ctrlStrobe_t strobe;
  logic        outFree;

  hamCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .inValid    (inValid),
    .inRowStart (inRowStart),
    .inReady    (inReady),
    .outFree    (outFree),
    .strobe     (strobe)
  );

  hamDatapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseColors (baseColors),
    .pixReady   (pixReady),
    .pixOut     (pixOut),
    .pixValid   (pixValid),
    .outFree    (outFree)
  );
endmodule

// File: rtl/hamDecoderChk.sv
module hamDecoderChk
  import hamPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inRowStart,
  input logic             inReady,
  input logic [PIX_W-1:0] pixOut,
  input logic             pixValid,
  input logic             pixReady
);
  logic [BCNT_W-1:0] phase;
  logic [BCNT_W-1:0] nextPhase;
  logic [2:0]        credit;
  logic              prevValid;
  logic              prevReady;
  logic              acc;
  logic              completes;
  logic              newPix;

  assign acc       = inValid && inReady;
  assign nextPhase = inRowStart ? BCNT_W'(1) : phase + 1'b1;
  assign completes = acc && (nextPhase == BCNT_W'(BYTES_PER_GROUP));
  assign newPix    = pixValid && (!prevValid || prevReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      credit    <= '0;
      prevValid <= 1'b0;
      prevReady <= 1'b0;
    end else begin
      prevValid <= pixValid;
      prevReady <= pixReady;
      if (acc) phase <= completes ? '0 : nextPhase;
      credit <= credit + (completes ? 3'd4 : 3'd0) - (newPix ? 3'd1 : 3'd0);
    end
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!pixValid && inReady));

  // R2
  a_r2_no_spurious_pixel: assert property (@(posedge clk) disable iff (!rstN)
    newPix |-> (credit != 3'd0));

  // R8
  a_r8_row_start_gathers: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inRowStart) |=> inReady);

  // R9
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixOut)));

  // R10
  a_r10_input_blocked: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> ((credit == 3'd0) || (credit == 3'd1 && newPix)));
endmodule

bind hamDecoder hamDecoderChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inRowStart (inRowStart),
  .inReady    (inReady),
  .pixOut     (pixOut),
  .pixValid   (pixValid),
  .pixReady   (pixReady)
);

// File: tb/sim_hamDecoder.sv
module sim_hamDecoder;
  import hamPkg::*;

  logic                      clk = 1'b0;
  logic                      rstN;
  logic [BYTE_W-1:0]         inData;
  logic                      inValid;
  logic                      inRowStart;
  logic                      inReady;
  logic [NUM_BASE*PIX_W-1:0] baseColors;
  logic [PIX_W-1:0]          pixOut;
  logic                      pixValid;
  logic                      pixReady;

  logic [PIX_W-1:0] baseC [NUM_BASE];
  logic [PIX_W-1:0] rxBuf [64];
  int               rxCnt;
  int               nChecks;
  int               nFails;
  logic [PIX_W-1:0] model;

  always #5 clk = ~clk;

  for (genvar i = 0; i < NUM_BASE; i++) begin : g_base
    assign baseColors[i*PIX_W +: PIX_W] = baseC[i];
  end

  hamDecoder u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inRowStart(inRowStart), .inReady(inReady), .baseColors(baseColors),
    .pixOut(pixOut), .pixValid(pixValid), .pixReady(pixReady)
  );

  always @(negedge clk) begin
    if (rstN && pixValid && pixReady) begin
      rxBuf[rxCnt % 64] = pixOut;
      rxCnt = rxCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  function automatic logic [5:0] cLoad(input int d);  return {3'b000, 3'(d)}; endfunction
  function automatic logic [5:0] cBlend(input int d); return {3'b001, 3'(d)}; endfunction
  function automatic logic [5:0] cAdj(input int ch, input int neg, input int d);
    return {2'(ch), 1'(neg), 3'(d)};
  endfunction

  // Reference from the requirements: R3 load, R4 blend, R5/R6 channel step
  function automatic logic [PIX_W-1:0] stepModel(input logic [PIX_W-1:0] cur, input logic [5:0] c);
    logic [PIX_W-1:0] b;
    logic [PIX_W-1:0] r;
    int v;
    int bi;
    b = baseC[c[2:0]];
    r = cur;
    if (c[5:3] == 3'b000) r = b;
    else if (c[5:3] == 3'b001) begin
      for (int k = 0; k < 3; k++)
        r[k*8 +: 8] = 8'((int'(cur[k*8 +: 8]) + int'(b[k*8 +: 8])) / 2);
    end else begin
      bi = 3 - int'(c[5:4]);  // 01 red -> top byte
      v  = int'(cur[bi*8 +: 8]) + (c[3] ? -1 : 1) * int'(c[2:0]) * 4;
      if (v > 255) v = 255;
      if (v < 0) v = 0;
      r[bi*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic sendByte(input logic [7:0] b, input bit rs);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inData = b; inValid = 1'b1; inRowStart = rs;
    @(negedge clk);
    inValid = 1'b0; inRowStart = 1'b0;
  endtask

  task automatic runGroup(input logic [5:0] c0, input logic [5:0] c1, input logic [5:0] c2,
                          input logic [5:0] c3, input bit rs, input bit stall, input string tag);
    logic [23:0] grp;
    logic [5:0]  cmds [4];
    logic [PIX_W-1:0] exp [4];
    logic [PIX_W-1:0] snap;
    int start;
    grp = {c0, c1, c2, c3};
    cmds[0] = c0; cmds[1] = c1; cmds[2] = c2; cmds[3] = c3;
    if (rs) model = baseC[0];
    for (int k = 0; k < 4; k++) begin
      model  = stepModel(model, cmds[k]);
      exp[k] = model;
    end
    start = rxCnt;
    if (stall) pixReady = 1'b0;
    sendByte(grp[23:16], rs);
    sendByte(grp[15:8], 1'b0);
    sendByte(grp[7:0], 1'b0);
    if (stall) begin
      repeat (2) @(negedge clk);
      snap = pixOut;
      check(pixValid === 1'b1, "R9 valid held", 32'(pixValid), 32'd1);
      check(pixOut === exp[0], "R9 first pixel under stall", 32'(pixOut), 32'(exp[0]));
      repeat (4) @(negedge clk);
      check(pixValid === 1'b1 && pixOut === snap, "R9 stable under stall", 32'(pixOut), 32'(snap));
      check(inReady === 1'b0, "R10 input blocked while emitting", 32'(inReady), 32'd0);
      pixReady = 1'b1;
    end
    for (int t = 0; t < 60 && rxCnt < start + 4; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rxCnt == start + 4, {tag, " R2 pixel count"}, 32'(rxCnt - start), 32'd4);
    for (int k = 0; k < 4; k++)
      check(rxBuf[(start + k) % 64] === exp[k], tag, 32'(rxBuf[(start + k) % 64]), 32'(exp[k]));
  endtask

  task automatic testReset();
    check(pixValid === 1'b0, "R1 pixValid after reset", 32'(pixValid), 32'd0);
    check(inReady === 1'b1, "R1 inReady after reset", 32'(inReady), 32'd1);
  endtask

  task automatic testLoads();
    runGroup(cLoad(0), cLoad(1), cLoad(2), cLoad(3), 1'b1, 1'b0, "R3 R2 loads 0-3");
    runGroup(cLoad(4), cLoad(5), cLoad(6), cLoad(7), 1'b0, 1'b0, "R3 loads 4-7");
  endtask

  task automatic testBlend();
    runGroup(cLoad(3), cBlend(6), cBlend(4), cBlend(1), 1'b0, 1'b0, "R4 blend");
  endtask

  task automatic testAdjust();
    runGroup(cLoad(0), cAdj(1, 0, 5), cAdj(2, 1, 3), cAdj(3, 0, 7), 1'b0, 1'b0, "R5 adjust");
    runGroup(cAdj(1, 1, 2), cAdj(2, 0, 1), cAdj(3, 1, 6), cAdj(1, 0, 0), 1'b0, 1'b0, "R7 carry across groups");
  endtask

  task automatic testSaturate();
    runGroup(cLoad(1), cAdj(1, 0, 7), cAdj(2, 1, 7), cAdj(3, 1, 4), 1'b0, 1'b0, "R6 saturate");
    runGroup(cLoad(4), cAdj(2, 0, 1), cLoad(7), cAdj(3, 1, 1), 1'b0, 1'b0, "R6 rails");
  endtask

  task automatic testRowRestart();
    sendByte({cLoad(7), 2'b00}, 1'b0);
    sendByte(8'h5a, 1'b0);
    runGroup(cAdj(1, 0, 1), cAdj(3, 1, 2), cBlend(2), cAdj(2, 0, 3), 1'b1, 1'b0, "R8 row restart");
  endtask

  task automatic testStall();
    runGroup(cLoad(6), cAdj(3, 0, 2), cBlend(5), cAdj(1, 1, 7), 1'b0, 1'b1, "R9 R10 stall");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    nChecks = 0; nFails = 0; rxCnt = 0; model = '0;
    rstN = 1'b0; inData = '0; inValid = 1'b0; inRowStart = 1'b0; pixReady = 1'b1;
    baseC[0] = 24'h8040C0; baseC[1] = 24'hFA0510; baseC[2] = 24'h00FF7F;
    baseC[3] = 24'h123456; baseC[4] = 24'hFFFFFF; baseC[5] = 24'h010203;
    baseC[6] = 24'hA55A3C; baseC[7] = 24'h000000;
    repeat (4) @(negedge clk);
    check(pixValid === 1'b0, "R1 pixValid in reset", 32'(pixValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoads();
    testBlend();
    testAdjust();
    testSaturate();
    testRowRestart();
    testStall();
    summary();
  end
endmodule